// File: doc/BRIEF.md
# Voltage and Frequency Step Sequencer

This block moves a processor core between a fast and a slow operating point. It keeps the supply safe during the move. A request names a target mode, where mode 0 is full speed and mode 1 is half speed; a smaller index always means a faster clock. When the core is sped up, the sequencer first runs a voltage handshake and only then reprograms the clock. When it is slowed down, the clock is changed first and the voltage handshake follows. The clock change is a fixed burst of three writes to a 32-bit clock-control port. After the burst the sequencer reads a 64-bit status word at spaced intervals until the change is reported done or a retry budget is used up.

The control word used for each mode sits in a small writable table. After reset the sequencer brings itself into a known state without any request. It raises the voltage to the full-speed level and waits. It then reads the speed the clock is running at from the status word and re-applies the matching mode. During this start-up the current mode is treated as unknown, so the voltage step comes after the clock step. All waits are derived from a prescaler, whose clock rate and time units are parameters.

Top module: `dvfs_seq_top`

## Requirements
- R1: While reset is held, `busy` is 1 and `pcr_we` and `volt_req` are 0. After reset is released, the first action is a voltage request with `volt_mode` = 0. No clock-control write happens until at least INIT_WAIT_MS milliseconds after that handshake ends.
- R2: After the start-up wait, the sequencer reads the status word once. It selects the lowest mode whose table speed field (bits 18:17) equals status bits 57:56, or mode 0 if no mode matches. It writes that mode's word, then runs a voltage handshake for that mode, and leaves `cur_mode` equal to it.
- R3: Every clock change is exactly three writes on consecutive cycles: data 0 (bit 31 clear), then 0x8000_0000, then 0x8000_0000 OR the table word of the target mode.
- R4: When the target mode index is below `cur_mode`, the voltage request for the target mode is raised and completed before the first clock-control write, and no voltage request follows the writes.
- R5: When the target mode index is above `cur_mode`, no voltage request occurs before the writes. A voltage request for the target mode follows the end of status polling.
- R6: A request for the mode already in effect performs the three writes and the polling but no voltage request.
- R7: Polling stops at the first status read where either bit 61 is 0 and bits 57:56 equal the requested speed bits 18:17, or bit 60 is 1.
- R8: When no read satisfies R7, polling stops after exactly POLL_TRIES reads. The sequence then completes normally and `cur_mode` takes the target.
- R9: Consecutive status reads within one poll are spaced by about POLL_GAP_US microseconds.
- R10: Each voltage handshake keeps `volt_req` high until `volt_done` is seen at a millisecond sample point. If `volt_done` does not come within VOLT_TMO_MS milliseconds, `volt_req` drops anyway, `volt_timeout` becomes 1 and stays 1 until reset, and the sequence continues.
- R11: `req_valid` is taken only while `busy` is 0. `busy` is 1 from the cycle after acceptance until the edge that updates `cur_mode`. A request made while busy is dropped and leaves no trace.
- R12: A table write whose speed field (bits 19:17) is 2 or more is ignored. Any other write replaces the word for that mode. At reset the table holds 0 for mode 0 and 0x0002_0000 for mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode change request strobe |
| req_mode | input | MODE_W | Requested mode (0 = full speed) |
| tbl_we | input | 1 | Mode table write enable |
| tbl_addr | input | MODE_W | Mode table entry to write |
| tbl_wdata | input | 32 | Clock-control word for that mode |
| volt_req | output | 1 | Voltage change request, held until done or timeout |
| volt_mode | output | MODE_W | Mode whose voltage is requested |
| volt_done | input | 1 | Voltage change completed |
| pcr_we | output | 1 | Clock-control write strobe |
| pcr_wdata | output | 32 | Clock-control write data, bit 31 selects low half |
| stat_rd | output | 1 | Status read strobe; status is sampled in this cycle |
| stat_data | input | 64 | Status word |
| cur_mode | output | MODE_W | Mode currently in effect |
| busy | output | 1 | Sequence in progress |
| volt_timeout | output | 1 | Sticky voltage handshake timeout flag |

## Verification
`busy` must read 1 one cycle after the edge that samples `req_valid`. The three writes must then appear on three consecutive cycles, and `stat_rd` must be high in exactly the cycles in which the status input is consumed. For that reason the bench samples every output half a cycle after the clock edge and logs ordering, read counts and spacing per transaction. Its status and voltage models react to the outputs at the next edge. Timed results (start-up wait, poll spacing, handshake timeout) depend on a free-running prescaler, so they are checked against windows one tick wide rather than against exact cycles. `cur_mode` and the flags are compared only once `busy` has fallen.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  localparam int CTL_SEL_BIT  = 31;
  localparam int CTL_SPD_LO   = 17;
  localparam int STAT_RECV    = 61;
  localparam int STAT_CMPL    = 60;
  localparam int STAT_SPD_LO  = 56;

  typedef enum logic [3:0] {
    ST_VOLT,
    ST_IWAIT,
    ST_IREAD,
    ST_IDLE,
    ST_WCLRH,
    ST_WCLRL,
    ST_WSET,
    ST_POLL,
    ST_GAP,
    ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    VP_INIT,
    VP_PRE,
    VP_POST
  } volt_phase_e;

endpackage

// File: rtl/dvfs_tick.sv
module dvfs_tick #(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic us_tick,
  output logic ms_tick
);
  localparam int UCW = $clog2(CYC_PER_US + 1);
  localparam int MCW = $clog2(US_PER_MS + 1);

  logic [UCW-1:0] ucnt_q;
  logic [MCW-1:0] mcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ucnt_q  <= '0;
      us_tick <= 1'b0;
    end else if (ucnt_q == UCW'(CYC_PER_US - 1)) begin
      ucnt_q  <= '0;
      us_tick <= 1'b1;
    end else begin
      ucnt_q  <= ucnt_q + 1'b1;
      us_tick <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt_q  <= '0;
      ms_tick <= 1'b0;
    end else begin
      ms_tick <= 1'b0;
      if (us_tick) begin
        if (mcnt_q == MCW'(US_PER_MS - 1)) begin
          mcnt_q  <= '0;
          ms_tick <= 1'b1;
        end else begin
          mcnt_q <= mcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dvfs_mode_table.sv
module dvfs_mode_table #(
  parameter int NUM_MODES = 2,
  parameter int MODE_W    = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [MODE_W-1:0]           waddr,
  input  logic [31:0]                 wdata,
  input  logic [MODE_W-1:0]           raddr,
  output logic [31:0]                 rdata,
  output logic [NUM_MODES-1:0][1:0]   speeds
);
  logic [31:0] mem [NUM_MODES];

  // speed codes 2 and up (quarter and beyond) are never stored
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MODES; i++)
        mem[i] <= (i == 0) ? 32'h0 : 32'h0002_0000;
    end else if (we && (wdata[19:17] < 3'd2)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_spd
    assign speeds[g] = mem[g][dvfs_pkg::CTL_SPD_LO+1:dvfs_pkg::CTL_SPD_LO];
  end
endmodule

// File: rtl/dvfs_fsm.sv
module dvfs_fsm
  import dvfs_pkg::*;
#(
  parameter int NUM_MODES    = 2,
  parameter int MODE_W       = 1,
  parameter int POLL_TRIES   = 10,
  parameter int POLL_GAP_US  = 100,
  parameter int VOLT_TMO_MS  = 100,
  parameter int INIT_WAIT_MS = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      us_tick,
  input  logic                      ms_tick,
  input  logic                      req_valid,
  input  logic [MODE_W-1:0]         req_mode,
  output logic [MODE_W-1:0]         tbl_raddr,
  input  logic [31:0]               tbl_word,
  input  logic [NUM_MODES-1:0][1:0] tbl_speeds,
  input  logic                      volt_done,
  input  logic                      stat_recv,
  input  logic                      stat_cmpl,
  input  logic [1:0]                stat_speed,
  output logic                      volt_req,
  output logic [MODE_W-1:0]         volt_mode,
  output logic                      volt_timeout,
  output logic                      pcr_we,
  output logic [31:0]               pcr_wdata,
  output logic                      stat_rd,
  output logic [MODE_W-1:0]         cur_mode,
  output logic                      busy
);
  localparam int WAIT_MAX = (VOLT_TMO_MS > INIT_WAIT_MS) ?
                            ((VOLT_TMO_MS > POLL_GAP_US) ? VOLT_TMO_MS : POLL_GAP_US) :
                            ((INIT_WAIT_MS > POLL_GAP_US) ? INIT_WAIT_MS : POLL_GAP_US);
  localparam int WCW   = $clog2(WAIT_MAX + 1);
  localparam int TRY_W = $clog2(POLL_TRIES + 1);
  localparam logic [31:0] SEL = 32'(1) << CTL_SEL_BIT;

  seq_state_e    state_q, state_n;
  volt_phase_e   vph_q, vph_n;
  logic [MODE_W-1:0] tgt_q, tgt_n, cur_n, match_m;
  logic          known_q, known_n, tmo_n, poll_ok;
  logic [31:0]   word_q, word_n;
  logic [WCW-1:0]   wcnt_q, wcnt_n;
  logic [TRY_W-1:0] tries_q, tries_n;

  assign tbl_raddr = tgt_q;
  assign poll_ok = (!stat_recv && (stat_speed == word_q[CTL_SPD_LO+1:CTL_SPD_LO])) || stat_cmpl;

  always_comb begin
    match_m = '0;
    for (int i = NUM_MODES - 1; i >= 0; i--)
      if (tbl_speeds[i] == stat_speed) match_m = MODE_W'(i);
  end

  always_comb begin
    state_n = state_q;  vph_n = vph_q;   tgt_n = tgt_q;   cur_n = cur_mode;
    known_n = known_q;  tmo_n = volt_timeout; word_n = word_q;
    wcnt_n  = wcnt_q;   tries_n = tries_q;
    case (state_q)
      ST_VOLT: if (ms_tick) begin
        if (volt_done || wcnt_q == WCW'(VOLT_TMO_MS - 1)) begin
          if (!volt_done) tmo_n = 1'b1;
          wcnt_n = '0;
          case (vph_q)
            VP_INIT: state_n = ST_IWAIT;
            VP_PRE:  state_n = ST_WCLRH;
            default: state_n = ST_FIN;
          endcase
        end else begin
          wcnt_n = wcnt_q + 1'b1;
        end
      end
      ST_IWAIT: if (ms_tick) begin
        if (wcnt_q == WCW'(INIT_WAIT_MS - 1)) begin
          wcnt_n = '0;  state_n = ST_IREAD;
        end else wcnt_n = wcnt_q + 1'b1;
      end
      ST_IREAD: begin
        tgt_n = match_m;  known_n = 1'b0;  state_n = ST_WCLRH;
      end
      ST_IDLE: if (req_valid) begin
        tgt_n = req_mode;
        if (known_q && (req_mode < cur_mode)) begin
          state_n = ST_VOLT;  vph_n = VP_PRE;
        end else state_n = ST_WCLRH;
      end
      ST_WCLRH: begin word_n = tbl_word; tries_n = '0; state_n = ST_WCLRL; end
      ST_WCLRL: state_n = ST_WSET;
      ST_WSET:  state_n = ST_POLL;
      ST_POLL: begin
        if (poll_ok || tries_q == TRY_W'(POLL_TRIES - 1)) begin
          if (!known_q || (tgt_q > cur_mode)) begin
            state_n = ST_VOLT;  vph_n = VP_POST;
          end else state_n = ST_FIN;
        end else begin
          tries_n = tries_q + 1'b1;  wcnt_n = '0;  state_n = ST_GAP;
        end
      end
      ST_GAP: if (us_tick) begin
        if (wcnt_q == WCW'(POLL_GAP_US - 1)) begin
          wcnt_n = '0;  state_n = ST_POLL;
        end else wcnt_n = wcnt_q + 1'b1;
      end
      ST_FIN: begin cur_n = tgt_q; known_n = 1'b1; state_n = ST_IDLE; end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_VOLT;  vph_q <= VP_INIT;  tgt_q <= '0;  cur_mode <= '0;
      known_q <= 1'b0;     word_q <= '0;      wcnt_q <= '0; tries_q <= '0;
      volt_timeout <= 1'b0;
      busy <= 1'b1;  volt_req <= 1'b0;  volt_mode <= '0;
      pcr_we <= 1'b0;  pcr_wdata <= '0;  stat_rd <= 1'b0;
    end else begin
      state_q <= state_n;  vph_q <= vph_n;  tgt_q <= tgt_n;  cur_mode <= cur_n;
      known_q <= known_n;  word_q <= word_n; wcnt_q <= wcnt_n; tries_q <= tries_n;
      volt_timeout <= tmo_n;
      busy      <= (state_n != ST_IDLE);
      volt_req  <= (state_n == ST_VOLT);
      volt_mode <= tgt_n;
      pcr_we    <= (state_n inside {ST_WCLRH, ST_WCLRL, ST_WSET});
      pcr_wdata <= (state_n == ST_WCLRL) ? SEL :
                   (state_n == ST_WSET)  ? (SEL | word_n) : 32'h0;
      stat_rd   <= (state_n == ST_POLL) || (state_n == ST_IREAD);
    end
  end
endmodule

// File: rtl/dvfs_seq_top.sv
module dvfs_seq_top #(
  parameter int CLK_HZ       = 100_000_000,
  parameter int US_PER_MS    = 1000,
  parameter int NUM_MODES    = 2,
  parameter int POLL_TRIES   = 10,
  parameter int POLL_GAP_US  = 100,
  parameter int VOLT_TMO_MS  = 100,
  parameter int INIT_WAIT_MS = 10,
  localparam int MODE_W      = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              tbl_we,
  input  logic [MODE_W-1:0] tbl_addr,
  input  logic [31:0]       tbl_wdata,
  output logic              volt_req,
  output logic [MODE_W-1:0] volt_mode,
  input  logic              volt_done,
  output logic              pcr_we,
  output logic [31:0]       pcr_wdata,
  output logic              stat_rd,
  input  logic [63:0]       stat_data,
  output logic [MODE_W-1:0] cur_mode,
  output logic              busy,
  output logic              volt_timeout
);
  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

  logic us_tick, ms_tick;
  logic [MODE_W-1:0] tbl_raddr;
  logic [31:0] tbl_word;
  logic [NUM_MODES-1:0][1:0] tbl_speeds;
  logic unused_stat;

  assign unused_stat = ^{stat_data[63:62], stat_data[59:58], stat_data[55:0]};

  dvfs_tick #(.CYC_PER_US(CYC_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .us_tick(us_tick), .ms_tick(ms_tick)
  );

  dvfs_mode_table #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_table (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(tbl_raddr), .rdata(tbl_word), .speeds(tbl_speeds)
  );

  dvfs_fsm #(
    .NUM_MODES(NUM_MODES), .MODE_W(MODE_W), .POLL_TRIES(POLL_TRIES),
    .POLL_GAP_US(POLL_GAP_US), .VOLT_TMO_MS(VOLT_TMO_MS), .INIT_WAIT_MS(INIT_WAIT_MS)
  ) u_fsm (
    .clk(clk), .rst(rst), .us_tick(us_tick), .ms_tick(ms_tick),
    .req_valid(req_valid), .req_mode(req_mode),
    .tbl_raddr(tbl_raddr), .tbl_word(tbl_word), .tbl_speeds(tbl_speeds),
    .volt_done(volt_done),
    .stat_recv(stat_data[dvfs_pkg::STAT_RECV]),
    .stat_cmpl(stat_data[dvfs_pkg::STAT_CMPL]),
    .stat_speed(stat_data[dvfs_pkg::STAT_SPD_LO+1:dvfs_pkg::STAT_SPD_LO]),
    .volt_req(volt_req), .volt_mode(volt_mode), .volt_timeout(volt_timeout),
    .pcr_we(pcr_we), .pcr_wdata(pcr_wdata), .stat_rd(stat_rd),
    .cur_mode(cur_mode), .busy(busy)
  );
endmodule

// File: rtl/dvfs_seq_checker.sv
module dvfs_seq_checker #(
  parameter int MODE_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              pcr_we,
  input logic [31:0]       pcr_wdata,
  input logic              volt_req,
  input logic              stat_rd,
  input logic              volt_timeout,
  input logic [MODE_W-1:0] cur_mode
);
  // R3: a clearing write of the high half is followed by the low-half clear
  p_clr_order_r3: assert property (@(posedge clk) disable iff (rst)
    (pcr_we && pcr_wdata == 32'h0) |=> (pcr_we && pcr_wdata == 32'h8000_0000));

  // R3: the low-half clear is followed by the low-half set (bit 31 high)
  p_set_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (pcr_we && $past(pcr_we) && $past(pcr_wdata) == 32'h0) |=> (pcr_we && pcr_wdata[31]));

  // R4: voltage handshake never overlaps clock-control writes
  p_no_volt_in_write_r4: assert property (@(posedge clk) disable iff (rst)
    pcr_we |-> !volt_req);

  // R9: status reads are separated by at least one idle cycle
  p_read_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> !stat_rd);

  // R10: timeout flag is sticky
  p_tmo_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    volt_timeout |=> volt_timeout);

  // R11: nothing is driven while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!pcr_we && !volt_req && !stat_rd));

  // R11: current mode only changes at the end of a sequence
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(cur_mode));
endmodule

bind dvfs_seq_top dvfs_seq_checker #(.MODE_W(MODE_W)) u_seq_chk (
  .clk(clk), .rst(rst), .busy(busy), .pcr_we(pcr_we), .pcr_wdata(pcr_wdata),
  .volt_req(volt_req), .stat_rd(stat_rd), .volt_timeout(volt_timeout),
  .cur_mode(cur_mode)
);

// File: tb/dvfs_seq_top_bench.sv
module dvfs_seq_top_bench;
  localparam int CYC_US = 2;
  localparam int USMS   = 10;
  localparam int MS_CYC = CYC_US * USMS;
  localparam int PT     = 10;
  localparam int GAP_US = 4;
  localparam int VTMO   = 6;
  localparam int IWAIT  = 3;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [0:0] req_mode = 0;
  logic tbl_we = 0;
  logic [0:0] tbl_addr = 0;
  logic [31:0] tbl_wdata = 0;
  logic volt_req, volt_done = 0, pcr_we, stat_rd, busy, volt_timeout;
  logic [0:0] volt_mode, cur_mode;
  logic [31:0] pcr_wdata;
  logic [63:0] stat_data;

  always #2 clk = ~clk;

  dvfs_seq_top #(
    .CLK_HZ(CYC_US * 1_000_000), .US_PER_MS(USMS), .NUM_MODES(2), .POLL_TRIES(PT),
    .POLL_GAP_US(GAP_US), .VOLT_TMO_MS(VTMO), .INIT_WAIT_MS(IWAIT)
  ) u_dvfs_seq_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .volt_req(volt_req), .volt_mode(volt_mode), .volt_done(volt_done),
    .pcr_we(pcr_we), .pcr_wdata(pcr_wdata), .stat_rd(stat_rd), .stat_data(stat_data),
    .cur_mode(cur_mode), .busy(busy), .volt_timeout(volt_timeout)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // ---------------- status model ----------------
  int psr_kind = 0, psr_k = 0, psr_reads = 0, wr_idx = 0;
  logic [1:0] psr_new = 2'd1;
  logic [1:0] psr_old;
  logic ready0, cmp1;
  assign psr_old = psr_new ^ 2'b01;
  assign ready0 = (psr_kind == 0) && (psr_reads >= psr_k);
  assign cmp1   = (psr_kind == 1) && (psr_reads >= psr_k);
  assign stat_data = ready0 ? {2'b00, 1'b0, 1'b0, 2'b00, psr_new, 56'h0}
                            : {2'b00, 1'b1, cmp1, 2'b00, psr_old, 56'h0};

  always @(posedge clk) begin
    if (rst) wr_idx <= 0;
    else if (pcr_we) begin
      if (wr_idx == 2) begin
        wr_idx <= 0; psr_new <= pcr_wdata[18:17]; psr_reads <= 0;
      end else wr_idx <= wr_idx + 1;
    end else if (stat_rd) psr_reads <= psr_reads + 1;
  end

  // ---------------- voltage model ----------------
  int vdelay = 3, vcnt = 0;
  bit volt_never = 0;
  always @(posedge clk) begin
    if (volt_req && !volt_never) vcnt <= vcnt + 1; else vcnt <= 0;
    volt_done <= volt_req && !volt_never && (vcnt >= vdelay);
  end

  // ---------------- monitor ----------------
  int cyc = 0, n_wr, n_rd, n_vb, n_va, last_rd, min_gap, max_gap;
  int first_wr_cyc, vfall_first, vlen;
  logic [31:0] wr [3];
  logic [0:0] vmode_first, vmode_last;
  bit vseen, prev_vreq = 0;

  task automatic mon_clear();
    n_wr = 0; n_rd = 0; n_vb = 0; n_va = 0; last_rd = 0;
    min_gap = 1 << 30; max_gap = 0; first_wr_cyc = -1; vfall_first = -1;
    vlen = 0; vseen = 0; vmode_first = 0; vmode_last = 0;
    for (int i = 0; i < 3; i++) wr[i] = 32'hDEAD_BEEF;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pcr_we) begin
      if (n_wr < 3) wr[n_wr] = pcr_wdata;
      if (n_wr == 0) first_wr_cyc = cyc;
      n_wr++;
    end
    if (stat_rd) begin
      if (n_rd > 0) begin
        if (cyc - last_rd < min_gap) min_gap = cyc - last_rd;
        if (cyc - last_rd > max_gap) max_gap = cyc - last_rd;
      end
      last_rd = cyc; n_rd++;
    end
    if (volt_req) begin
      if (!vseen) vmode_first = volt_mode;
      vseen = 1; vmode_last = volt_mode; vlen++;
      if (n_wr == 0) n_vb++; else n_va++;
    end
    if (prev_vreq && !volt_req && vfall_first < 0) vfall_first = cyc;
    prev_vreq = volt_req;
  end

  // ---------------- helpers ----------------
  logic [31:0] tbl_m [2];
  int model_cur = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wait_idle(input int lim);
    int t = 0;
    @(negedge clk);
    while (busy && t < lim) begin @(negedge clk); t++; end
    check(!busy, "R11 sequence ends (busy falls)", busy, 0);
  endtask

  task automatic do_req(input int mode, input int kind, input int k, input int vdel);
    int prev, exp_rd;
    prev = model_cur;
    psr_kind = kind; psr_k = k; vdelay = vdel;
    @(negedge clk);
    mon_clear();
    req_valid = 1; req_mode = 1'(mode);
    @(negedge clk);
    req_valid = 0;
    check(busy == 1, "R11 busy one cycle after acceptance", busy, 1);
    wait_idle(4000);
    check(cur_mode == 1'(mode), "R11 cur_mode updated", cur_mode, mode);
    check(n_wr == 3 && wr[0] == 32'h0 && wr[1] == 32'h8000_0000 &&
          wr[2] == (32'h8000_0000 | tbl_m[mode]), "R3 write burst", wr[2],
          32'h8000_0000 | tbl_m[mode]);
    exp_rd = (kind == 2) ? PT : k + 1;
    check(n_rd == exp_rd, (kind == 2) ? "R8 poll budget" : "R7 poll stop", n_rd, exp_rd);
    if (n_rd > 1)
      check(min_gap >= (GAP_US - 1) * CYC_US + 1 && max_gap <= GAP_US * CYC_US + 2,
            "R9 poll spacing", min_gap, GAP_US * CYC_US);
    if (mode < prev)
      check(n_vb > 0 && n_va == 0 && vmode_last == 1'(mode), "R4 voltage before speed-up",
            {n_vb, n_va}, mode);
    else if (mode > prev)
      check(n_vb == 0 && n_va > 0 && vmode_last == 1'(mode), "R5 voltage after slow-down",
            {n_vb, n_va}, mode);
    else
      check(n_vb == 0 && n_va == 0, "R6 same mode no voltage", {n_vb, n_va}, 0);
    model_cur = mode;
  endtask

  task automatic do_reset(input logic [1:0] spd);
    rst = 1; psr_new = spd; psr_kind = 0; psr_k = 0; vdelay = 3; volt_never = 0;
    tbl_m[0] = 32'h0; tbl_m[1] = 32'h0002_0000;
    repeat (5) @(negedge clk);
    check(busy == 1 && pcr_we == 0 && volt_req == 0, "R1 reset state",
          {busy, pcr_we, volt_req}, 3'b100);
    mon_clear();
    rst = 0;
    wait_idle(3000);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd4242));
    mon_clear();

    // start-up with status reporting half speed
    do_reset(2'd1);
    check(vmode_first == 0, "R1 first voltage request is full speed", vmode_first, 0);
    check(first_wr_cyc - vfall_first >= (IWAIT - 1) * MS_CYC, "R1 start-up wait",
          first_wr_cyc - vfall_first, IWAIT * MS_CYC);
    check(cur_mode == 1 && wr[2] == 32'h8002_0000, "R2 start-up applies matched mode",
          wr[2], 32'h8002_0000);
    check(n_va > 0 && vmode_last == 1, "R2 start-up voltage after clock", {n_va, vmode_last}, 1);
    model_cur = 1;

    // directed orderings
    do_req(0, 0, 0, 5);     // speed up
    do_req(0, 0, 2, 5);     // same mode
    do_req(1, 1, 3, 5);     // slow down, completed bit
    do_req(0, 2, 0, 5);     // budget exhausted

    // random mix
    for (int i = 0; i < 24; i++)
      do_req(int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
             int'($urandom_range(0, 4)), int'($urandom_range(0, 60)));

    // voltage handshake timeout on a speed-up
    if (model_cur == 0) do_req(1, 0, 0, 5);
    volt_never = 1;
    do_req(0, 0, 1, 5);
    check(volt_timeout == 1, "R10 timeout flag set", volt_timeout, 1);
    check(vlen >= (VTMO - 1) * MS_CYC && vlen <= VTMO * MS_CYC + 1, "R10 timeout length",
          vlen, VTMO * MS_CYC);
    volt_never = 0;
    do_req(1, 0, 0, 5);
    check(volt_timeout == 1, "R10 flag sticky", volt_timeout, 1);

    // request while busy is dropped
    psr_kind = 0; psr_k = 3;
    @(negedge clk); mon_clear();
    req_valid = 1; req_mode = 1'(0);
    @(negedge clk); req_valid = 0;
    repeat (3) @(negedge clk);
    req_valid = 1; req_mode = 1'(1);
    @(negedge clk); req_valid = 0;
    wait_idle(4000);
    check(cur_mode == 0, "R11 busy request ignored (mode)", cur_mode, 0);
    mon_clear();
    repeat (30) @(negedge clk);
    check(busy == 0 && n_wr == 0, "R11 busy request ignored (no replay)", n_wr, 0);
    model_cur = 0;

    // table writes
    @(negedge clk);
    tbl_we = 1; tbl_addr = 1'(1); tbl_wdata = 32'h0004_0000;
    @(negedge clk);
    tbl_we = 0;
    do_req(1, 0, 0, 5);
    check(wr[2] == 32'h8002_0000, "R12 quarter-speed word ignored", wr[2], 32'h8002_0000);
    do_req(0, 0, 0, 5);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 1'(1); tbl_wdata = 32'h0002_00A5;
    @(negedge clk);
    tbl_we = 0; tbl_m[1] = 32'h0002_00A5;
    do_req(1, 0, 0, 5);
    check(wr[2] == 32'h8002_00A5, "R12 table word accepted", wr[2], 32'h8002_00A5);

    // start-up with unmatched status speed
    do_reset(2'd3);
    check(cur_mode == 0 && wr[2] == 32'h8000_0000, "R2 no match falls back to mode 0",
          wr[2], 32'h8000_0000);
    check(volt_timeout == 0, "R10 flag cleared by reset", volt_timeout, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule